// File: doc/BRIEF.md
# Serial Flash Identification and Status Responder

This block is the device end of a serial peripheral interface (mode 0) for a flash memory model. It answers only the identification and status commands. It decodes the first byte of each select as an opcode and streams the matching reply on the data-out line: a fixed three-byte signature, a two-value identifier chosen by an address bit, or the status byte. It also keeps the status register, which the write-enable, write-disable, status-unlock and status-write commands change. The memory array and the timing of program and erase are not part of it.

The serial inputs are sampled in the `clk` domain. The block finds the edges of the serial clock there. The master must keep each serial clock level for at least one `clk` cycle. A command takes effect only when chip select rises on a whole-byte boundary.

Top module: `spi_flash_id_responder`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `miso` is 0 and `miso_oe` is 0. Reset clears the status register to 00h. `miso_oe` is 1 while `cs_n` is low.
- R2: Opcode 9Fh returns BFh, 25h and 8Dh in that order, then repeats from BFh for as long as bytes are clocked.
- R3: Opcode 90h or ABh is followed by three address bytes, during which the reply is 00h. If bit 0 of the last address byte is 0, the reply is BFh, then 8Dh, then BFh, alternating without end.
- R4: Under the same opcodes, if bit 0 of the last address byte is 1, the reply starts with 8Dh and then alternates with BFh.
- R5: Opcode 05h returns the status byte in every byte after the opcode. Bit 1 is the write-enable flag, bit 0 is the busy flag (always 0 here), and bits 7:2 are the protection field.
- R6: Opcode 06h sets status bit 1 and opcode 04h clears it. Either takes effect only if chip select rises after exactly one whole byte.
- R7: Opcode 01h followed by one data byte, with chip select rising after exactly two whole bytes, loads bits 7:2 of the data into the protection field. This holds only when the previous completed select was opcode 50h alone. Bits 1:0 are unaffected.
- R8: A status write that does not directly follow an unlock (50h) select leaves the status unchanged.
- R9: If chip select rises partway through a byte, no state changes.
- R10: An unsupported opcode produces 00h replies for the rest of the select and changes no state.
- R11: MOSI is sampled MSB first on rising SCK, and MISO changes on falling SCK, MSB first. The first reply bit appears on the falling edge that follows the eighth rising edge.
- R12: A rise of chip select resets the decode state, so the next select starts with a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the master, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, 0 while deselected |
| miso_oe | output | 1 | High while selected, for a pad tri-state |

## Verification
The embedded properties assume the following about the inputs:
- `sck`, `cs_n` and `mosi` are already synchronous to `clk`.
- Every level of `sck` lasts at least one `clk` cycle.
- Chip select never changes in the same cycle as a serial clock edge.

The stimulus meets these assumptions in three ways. It changes inputs only on the falling `clk` edge. It holds every serial clock level for two `clk` cycles. It leaves idle cycles around each select edge. Replies are sampled just before each rising SCK, the same point at which a master would sample them.

// File: rtl/spi_id_pkg.sv
// Package: opcode values, identity bytes and command classes shared by the
// responder modules. Assumes 8-bit opcodes sent MSB first.
package spi_id_pkg;

    localparam logic [7:0] OP_SIG_READ   = 8'h9F;
    localparam logic [7:0] OP_ID_ADDR_A  = 8'h90;
    localparam logic [7:0] OP_ID_ADDR_B  = 8'hAB;
    localparam logic [7:0] OP_STAT_READ  = 8'h05;
    localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OP_WR_DISABLE = 8'h04;
    localparam logic [7:0] OP_STAT_OPEN  = 8'h50;
    localparam logic [7:0] OP_STAT_WRITE = 8'h01;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_SIG,
        CK_LEGACY,
        CK_STAT,
        CK_WEN,
        CK_WDIS,
        CK_OPEN,
        CK_WSTAT
    } cmd_kind_e;

    // Map an opcode byte to its command class.
    function automatic cmd_kind_e decode_op(input logic [7:0] op);
        case (op)
            OP_SIG_READ:   return CK_SIG;
            OP_ID_ADDR_A:  return CK_LEGACY;
            OP_ID_ADDR_B:  return CK_LEGACY;
            OP_STAT_READ:  return CK_STAT;
            OP_WR_ENABLE:  return CK_WEN;
            OP_WR_DISABLE: return CK_WDIS;
            OP_STAT_OPEN:  return CK_OPEN;
            OP_STAT_WRITE: return CK_WSTAT;
            default:       return CK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_id_edge.sv
// Edge finder: registers SCK and chip select in the clk domain and flags
// rising/falling SCK while selected and the rise of chip select.
// Assumes inputs are synchronous to clk and each SCK level lasts >= 1 cycle.
module spi_id_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    // Hold the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;

endmodule

// File: rtl/spi_id_rx.sv
// Receive path: shifts MOSI in MSB first on rising SCK, counts bits in the
// current byte and whole bytes in the current select (saturating).
// Assumes sck_rise is already gated by chip select; all state clears while
// chip select is high.
module spi_id_rx #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck_rise,
    input  logic             mosi,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic [2:0]       bit_cnt,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [6:0] sr_q;

    assign rx_byte   = {sr_q, mosi};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);

    // Shift register and counters, cleared between selects.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sr_q     <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (sck_rise) begin
            sr_q    <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && byte_cnt != CNT_MAX)
                byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // R11: within one select the byte count never goes backwards
    a_r11_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> (byte_cnt >= $past(byte_cnt)));

    // R12: a deselected cycle leaves the receive state empty
    a_r12_clear_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (bit_cnt == 3'd0 && byte_cnt == '0));

endmodule

// File: rtl/spi_id_status.sv
// Status register: protection field [7:2], write-enable [1], busy [0] (no
// program/erase here, so always 0). Changes are committed only on a clean
// end of select (end_ok). A status write needs the unlock select just before.
module spi_id_status
    import spi_id_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      end_ok,
    input  cmd_kind_e kind,
    input  logic      one_byte,
    input  logic      two_bytes,
    input  logic [7:0] wr_data,
    output logic [7:0] status
);
    logic [5:0] prot_q;
    logic       wen_q;
    logic       armed_q;

    assign status = {prot_q, wen_q, 1'b0};

    // Write-enable flag from the single-byte enable/disable commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wen_q <= 1'b0;
        else if (end_ok && one_byte && kind == CK_WEN)
            wen_q <= 1'b1;
        else if (end_ok && one_byte && kind == CK_WDIS)
            wen_q <= 1'b0;
    end

    // Unlock marker: valid only for the select right after the unlock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (end_ok)
            armed_q <= (kind == CK_OPEN) && one_byte;
    end

    // Protection field written by an unlocked two-byte status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= '0;
        else if (end_ok && two_bytes && kind == CK_WSTAT && armed_q)
            prot_q <= wr_data[7:2];
    end

    // R6: enable command leaves the flag set
    a_r6_wen_set: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && one_byte && kind == CK_WEN) |=> status[1]);

    // R6: disable command leaves the flag clear
    a_r6_wen_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && one_byte && kind == CK_WDIS) |=> !status[1]);

    // R7: a status write never touches bits 1:0
    a_r7_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && kind == CK_WSTAT) |=> (status[1:0] == $past(status[1:0])));

    // R8: a status write without the unlock changes nothing
    a_r8_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && kind == CK_WSTAT && !armed_q) |=> $stable(status));

endmodule

// File: rtl/spi_flash_id_responder.sv
// Top: decodes the opcode of each select and streams identity or status
// bytes on MISO (changed on falling SCK). It commits status commands when
// chip select rises on a byte boundary. Assumes mode 0 and synchronous inputs.
module spi_flash_id_responder
    import spi_id_pkg::*;
#(
    parameter int         CNT_W    = 3,
    parameter logic [7:0] MFR_ID   = 8'hBF,
    parameter logic [7:0] MEM_TYPE = 8'h25,
    parameter logic [7:0] DEV_ID   = 8'h8D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    localparam logic [CNT_W-1:0] N0 = '0;
    localparam logic [CNT_W-1:0] N1 = CNT_W'(1);
    localparam logic [CNT_W-1:0] N2 = CNT_W'(2);
    localparam logic [CNT_W-1:0] N3 = CNT_W'(3);

    logic             sck_rise, sck_fall, cs_rise;
    logic             byte_done;
    logic [7:0]       rx_byte;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] byte_cnt;
    logic [7:0]       status;

    cmd_kind_e  kind_q;
    logic [1:0] seq_q, seq_n;
    logic       alt_q, alt_n;
    logic [7:0] tx_sr, nxt;
    logic       miso_q;
    logic [7:0] wr_data_q;
    logic       end_ok;

    spi_id_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spi_id_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .mosi(mosi),
        .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt)
    );

    assign end_ok = cs_rise && (bit_cnt == 3'd0) && (byte_cnt != N0);

    spi_id_status u_status (
        .clk(clk), .rst_n(rst_n), .end_ok(end_ok), .kind(kind_q),
        .one_byte(byte_cnt == N1), .two_bytes(byte_cnt == N2),
        .wr_data(wr_data_q), .status(status)
    );

    // Signature byte for a rotation index.
    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return MFR_ID;
            2'd1:    return MEM_TYPE;
            default: return DEV_ID;
        endcase
    endfunction

    // Pick the reply byte to load when a byte completes.
    always_comb begin
        nxt   = 8'h00;
        seq_n = seq_q;
        alt_n = alt_q;
        if (byte_cnt == N0) begin
            case (decode_op(rx_byte))
                CK_SIG:  begin nxt = MFR_ID; seq_n = 2'd1; end
                CK_STAT: nxt = status;
                default: ;
            endcase
        end else begin
            case (kind_q)
                CK_SIG: begin
                    nxt   = sig_byte(seq_q);
                    seq_n = (seq_q == 2'd2) ? 2'd0 : seq_q + 2'd1;
                end
                CK_STAT: nxt = status;
                CK_LEGACY: begin
                    if (byte_cnt == N3) begin
                        nxt   = rx_byte[0] ? DEV_ID : MFR_ID;
                        alt_n = ~rx_byte[0];
                    end else if (byte_cnt > N3) begin
                        nxt   = alt_q ? DEV_ID : MFR_ID;
                        alt_n = ~alt_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // Command class, rotation state and transmit shifter for the select.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            kind_q <= CK_NONE;
            seq_q  <= 2'd0;
            alt_q  <= 1'b0;
            tx_sr  <= 8'h00;
            miso_q <= 1'b0;
        end else if (byte_done) begin
            tx_sr <= nxt;
            seq_q <= seq_n;
            alt_q <= alt_n;
            if (byte_cnt == N0)
                kind_q <= decode_op(rx_byte);
        end else if (sck_fall) begin
            miso_q <= tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
        end
    end

    // Capture the data byte of a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_data_q <= 8'h00;
        else if (byte_done && byte_cnt == N1 && kind_q == CK_WSTAT)
            wr_data_q <= rx_byte;
    end

    assign miso    = miso_q & ~cs_n;
    assign miso_oe = ~cs_n;

    // R1: output register is quiet after any deselected cycle
    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso_q);

    // R11: MISO register only moves on a falling serial clock
    a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sck_fall) |=> (miso_q == $past(miso_q)));

endmodule

// File: tb/tb_spi_flash_id_responder.sv
module tb_spi_flash_id_responder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_flash_id_responder dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
    );

    // Vector: {req, nbytes, mosi bytes 0..6, expected miso bytes 0..6}
    localparam int NV = 17;
    localparam logic [127:0] VEC [NV] = '{
        {8'd2,  8'd7, 56'h9F000000000000, 56'h00BF258DBF258D}, // R2 signature wraps
        {8'd3,  8'd7, 56'h90000000000000, 56'h00000000BF8DBF}, // R3 A0=0
        {8'd4,  8'd7, 56'hAB000001000000, 56'h000000008DBF8D}, // R4 A0=1
        {8'd5,  8'd3, 56'h05000000000000, 56'h00000000000000}, // R5 status 00
        {8'd6,  8'd1, 56'h06000000000000, 56'h00000000000000}, // R6 enable
        {8'd6,  8'd3, 56'h05000000000000, 56'h00020200000000}, // R6 flag set
        {8'd7,  8'd1, 56'h50000000000000, 56'h00000000000000}, // R7 unlock
        {8'd7,  8'd2, 56'h01FC0000000000, 56'h00000000000000}, // R7 write FC
        {8'd7,  8'd3, 56'h05000000000000, 56'h00FEFE00000000}, // R7 result
        {8'd8,  8'd2, 56'h01000000000000, 56'h00000000000000}, // R8 locked write
        {8'd8,  8'd3, 56'h05000000000000, 56'h00FEFE00000000}, // R8 unchanged
        {8'd6,  8'd1, 56'h04000000000000, 56'h00000000000000}, // R6 disable
        {8'd6,  8'd3, 56'h05000000000000, 56'h00FCFC00000000}, // R6 flag clear
        {8'd10, 8'd3, 56'h3C000000000000, 56'h00000000000000}, // R10 unsupported
        {8'd10, 8'd3, 56'h05000000000000, 56'h00FCFC00000000}, // R10 no change
        {8'd6,  8'd2, 56'h06010000000000, 56'h00000000000000}, // R6 extra byte
        {8'd6,  8'd3, 56'h05000000000000, 56'h00FCFC00000000}  // R6 ignored
    };

    task automatic check(input int req, input logic [55:0] got, input logic [55:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_begin();
        cs_n = 1'b0;
        cycles(2);
    endtask

    task automatic sel_end();
        cs_n = 1'b1;
        cycles(3);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            cycles(2);
            rx[i] = miso;
            sck = 1'b1;
            cycles(2);
            sck = 1'b0;
            cycles(2);
        end
    endtask

    task automatic status_read(input int req, input logic [7:0] exp);
        logic [7:0] b0, b1;
        sel_begin();
        xfer(8'h05, 8, b0);
        xfer(8'h00, 8, b1);
        sel_end();
        check(req, {40'd0, b0, b1}, {40'd0, 8'h00, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [55:0] got, exp;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        // R1 reset state at the pins
        check(1, {54'd0, miso, miso_oe}, 56'd0);

        for (int v = 0; v < NV; v++) begin
            int n;
            n = int'(VEC[v][119:112]);
            got = '0;
            exp = '0;
            sel_begin();
            if (v == 0) check(1, {55'd0, miso_oe}, 56'd1); // R1 enabled while selected
            for (int k = 0; k < n; k++) begin
                xfer(VEC[v][111 - 8*k -: 8], 8, b);
                got[55 - 8*k -: 8] = b;
                exp[55 - 8*k -: 8] = VEC[v][55 - 8*k -: 8];
            end
            sel_end();
            check(int'(VEC[v][127:120]), got, exp);
        end

        // R9: partial enable command (5 bits) changes nothing
        sel_begin();
        xfer(8'h06, 5, b);
        sel_end();
        status_read(9, 8'hFC);

        // R12: cut signature short, next select decodes a fresh opcode
        sel_begin();
        xfer(8'h9F, 8, b);
        xfer(8'h00, 8, b);
        sel_end();
        check(12, {48'd0, b}, {48'd0, 8'hBF});
        status_read(12, 8'hFC);

        // R11: reply bit appears only after the falling edge
        sel_begin();
        xfer(8'h9F, 7, b);
        mosi = 1'b1;
        cycles(2);
        sck = 1'b1;
        cycles(2);
        check(11, {55'd0, miso}, 56'd0);
        sck = 1'b0;
        cycles(2);
        check(11, {55'd0, miso}, 56'd1);
        sel_end();
        // R1 deselected output low
        check(1, {54'd0, miso, miso_oe}, 56'd0);

        // R1: reset clears the status register
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        status_read(1, 8'h00);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule